// File: doc/BRIEF.md
# Coil Switch Protection Sequencer

This block sequences the gate of a power switch that charges an ignition coil. It works on digital samples: a command level, an active-low enable, comparator flags for input overvoltage, supply overvoltage, over-temperature and two coil-current levels (flag threshold reached, current at zero), and a bond-fault flag. It drives three outputs. The first is the gate command. The second is a soft-shutdown clamp enable that lets the coil discharge slowly instead of firing a spark. The third is an active-low current-flag output.

The command and enable inputs pass through deglitch filters before the sequencer uses them. Once the block is enabled, a filtered command rising edge switches the coil on. A filtered falling edge switches it off and fires the spark. Any fault seen while the coil is on moves the block into the clamp state. Each fault type has its own rule for leaving the clamp and its own rule for restarting. The flag output is filtered and reports when the coil current has not yet reached the flag threshold. All pins are plain control and status levels, so there is no handshake.

Top module: `coil_guard_seq`

## Requirements
- R1: Synchronous active-high reset drives gate_on=0, clamp_on=0 and flag_n=1. A command that is already high during reset never counts as a rising edge.
- R2: en_n_in is active low (0 = enabled). After reset the filtered enable starts in the disabled state, so a block whose enable is held at 1 never turns on.
- R3: A change on cmd_in or en_n_in is accepted only after 32 consecutive samples at the new level, and a shorter pulse is ignored. A command rise held from one clock edge turns the gate on at the 33rd edge.
- R4: When enabled, a filtered command rising edge sets gate_on=1. A filtered falling edge clears it with clamp_on=0.
- R5: gate_on and clamp_on are never both 1. The clamp is only entered directly from the on state.
- R6: If the enable goes inactive while the coil is on, the clamp engages. It stays engaged until i_zero=1, even if the enable returns. Restart then needs the enable active and a new command rising edge.
- R7: If hot=1 while the coil is on, the clamp engages. It releases when i_zero=1, or at once when the filtered command falls. The gate cannot turn on while hot=1.
- R8: Supply overvoltage acts only after 440 consecutive samples high, and the count restarts if the input drops earlier. The clamp then holds until i_zero=1. Turn-on is blocked while sup_ov=1, and after it clears only a new command rising edge restarts the switch.
- R9: Input overvoltage engages the clamp only while inp_ov=1. When it clears with the command still high, enabled and no other fault present, gate_on returns to 1 on the next edge without a new rising edge.
- R10: A bond fault while the coil is on engages the clamp until i_zero=1, even if the fault flag clears.
- R11: flag_n falls 16 clocks after gate_on rises. It returns high 16 clocks after i_at_flag is seen during the on state, and it stays high until the next turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (nominal 2 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Raw command level |
| en_n_in | input | 1 | Raw enable, active low |
| inp_ov | input | 1 | Command input overvoltage comparator |
| sup_ov | input | 1 | Supply overvoltage comparator (hysteresis external) |
| hot | input | 1 | Over-temperature comparator (hysteresis external) |
| i_at_flag | input | 1 | Coil current has reached the flag threshold |
| i_zero | input | 1 | Coil current is at zero |
| bond_fault | input | 1 | Internal bond-wire fault flag |
| gate_on | output | 1 | Power switch gate command |
| clamp_on | output | 1 | Soft-shutdown clamp enable |
| flag_n | output | 1 | Current flag, low while charging below threshold |

## Verification
The hardest case to reach is a fault that lands inside a live coil-on window and then meets a second event before discharge finishes. Examples are the command falling during a thermal clamp, the enable returning during an enable clamp, and a supply overvoltage that has to outlast its 440-sample window. Directed tasks first bring the gate up through the full 32-sample filter. They then hold i_zero low so the clamp cannot finish by itself, and inject the second event at a counted edge. The checks sample the clamp and gate at the exact edge where each release rule takes effect.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_SOFT = 2'd2
  } seq_state_t;

  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_THERM = 3'd1,
    CZ_BOND  = 3'd2,
    CZ_INPOV = 3'd3,
    CZ_SUPOV = 3'd4,
    CZ_EN    = 3'd5
  } clamp_cause_t;
endpackage

// File: rtl/cgs_filter.sv
module cgs_filter #(
  parameter int unsigned N = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic raw,
  output logic q
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= rst_val;
      cnt <= '0;
    end else if (raw == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= raw;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cgs_persist.sv
module cgs_persist #(
  parameter int unsigned HOLD = 440
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic act
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !lvl) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (!act) begin
      if (cnt == LAST) begin
        act <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cgs_core.sv
module cgs_core
  import cgs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_init,
  input  logic cmd_f,
  input  logic en_n_f,
  input  logic inp_ov,
  input  logic sov_act,
  input  logic hot,
  input  logic bond_fault,
  input  logic i_at_flag,
  input  logic i_zero,
  output logic gate_on,
  output logic clamp_on,
  output logic want_flag_n
);
  seq_state_t   state_q, state_d;
  clamp_cause_t cause_q, cause_d;
  logic prev_q;
  logic thr_q;
  logic rise, fall, en_ok, no_block;

  assign rise     = cmd_f & ~prev_q;
  assign fall     = ~cmd_f & prev_q;
  assign en_ok    = ~en_n_f;
  assign no_block = en_ok & ~hot & ~bond_fault & ~inp_ov & ~sov_act;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_OFF: begin
        if (rise && no_block) state_d = ST_ON;
      end
      ST_ON: begin
        if (fall) begin
          state_d = ST_OFF;
        end else if (hot) begin
          state_d = ST_SOFT; cause_d = CZ_THERM;
        end else if (bond_fault) begin
          state_d = ST_SOFT; cause_d = CZ_BOND;
        end else if (inp_ov) begin
          state_d = ST_SOFT; cause_d = CZ_INPOV;
        end else if (sov_act) begin
          state_d = ST_SOFT; cause_d = CZ_SUPOV;
        end else if (!en_ok) begin
          state_d = ST_SOFT; cause_d = CZ_EN;
        end
      end
      ST_SOFT: begin
        unique case (cause_q)
          CZ_THERM: if (!cmd_f || i_zero) state_d = ST_OFF;
          CZ_INPOV: if (!inp_ov) state_d = (cmd_f && no_block) ? ST_ON : ST_OFF;
          default:  if (i_zero) state_d = ST_OFF;
        endcase
      end
      default: state_d = ST_OFF;
    endcase
    if (state_d != ST_SOFT) cause_d = CZ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cause_q <= CZ_NONE;
      prev_q  <= cmd_init;
      thr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      prev_q  <= cmd_f;
      thr_q   <= (state_q == ST_ON) ? (thr_q | i_at_flag) : 1'b0;
    end
  end

  assign gate_on     = (state_q == ST_ON);
  assign clamp_on    = (state_q == ST_SOFT);
  assign want_flag_n = ~((state_q == ST_ON) & ~thr_q);
endmodule

// File: rtl/coil_guard_seq.sv
module coil_guard_seq #(
  parameter int unsigned CMD_FILT  = 32,
  parameter int unsigned EN_FILT   = 32,
  parameter int unsigned FLAG_FILT = 16,
  parameter int unsigned SOV_HOLD  = 440
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_in,
  input  logic en_n_in,
  input  logic inp_ov,
  input  logic sup_ov,
  input  logic hot,
  input  logic i_at_flag,
  input  logic i_zero,
  input  logic bond_fault,
  output logic gate_on,
  output logic clamp_on,
  output logic flag_n
);
  logic cmd_f, en_n_f, sov_act, want_flag_n;

  cgs_filter #(.N(CMD_FILT)) u_cmd_filt (
    .clk(clk), .rst(rst), .rst_val(cmd_in), .raw(cmd_in), .q(cmd_f)
  );

  cgs_filter #(.N(EN_FILT)) u_en_filt (
    .clk(clk), .rst(rst), .rst_val(1'b1), .raw(en_n_in), .q(en_n_f)
  );

  cgs_persist #(.HOLD(SOV_HOLD)) u_sov (
    .clk(clk), .rst(rst), .lvl(sup_ov), .act(sov_act)
  );

  cgs_core u_core (
    .clk(clk), .rst(rst), .cmd_init(cmd_in), .cmd_f(cmd_f), .en_n_f(en_n_f),
    .inp_ov(inp_ov), .sov_act(sov_act), .hot(hot), .bond_fault(bond_fault),
    .i_at_flag(i_at_flag), .i_zero(i_zero), .gate_on(gate_on),
    .clamp_on(clamp_on), .want_flag_n(want_flag_n)
  );

  cgs_filter #(.N(FLAG_FILT)) u_flag_filt (
    .clk(clk), .rst(rst), .rst_val(1'b1), .raw(want_flag_n), .q(flag_n)
  );
endmodule

// File: rtl/coil_guard_chk.sv
module coil_guard_chk (
  input logic clk,
  input logic rst,
  input logic hot,
  input logic bond_fault,
  input logic inp_ov,
  input logic gate_on,
  input logic clamp_on,
  input logic flag_n
);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_on && clamp_on));

  a_r5_clamp_from_on: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_on) |-> $past(gate_on));

  a_r7_no_start_hot: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> !$past(hot));

  a_r10_no_start_bond: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> !$past(bond_fault));

  a_r9_no_start_inpov: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> !$past(inp_ov));

  a_r11_flag_fall_on: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_n) |-> $past(gate_on));
endmodule

bind coil_guard_seq coil_guard_chk u_chk (
  .clk(clk), .rst(rst), .hot(hot), .bond_fault(bond_fault), .inp_ov(inp_ov),
  .gate_on(gate_on), .clamp_on(clamp_on), .flag_n(flag_n)
);

// File: tb/sim_coil_guard_seq.sv
`timescale 1ns/1ps
module sim_coil_guard_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_in = 1'b0, en_n_in = 1'b0, inp_ov = 1'b0, sup_ov = 1'b0;
  logic hot = 1'b0, i_at_flag = 1'b0, i_zero = 1'b0, bond_fault = 1'b0;
  logic gate_on, clamp_on, flag_n;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  coil_guard_seq u0 (
    .clk(clk), .rst(rst), .cmd_in(cmd_in), .en_n_in(en_n_in), .inp_ov(inp_ov),
    .sup_ov(sup_ov), .hot(hot), .i_at_flag(i_at_flag), .i_zero(i_zero),
    .bond_fault(bond_fault), .gate_on(gate_on), .clamp_on(clamp_on), .flag_n(flag_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic cmd_lvl, input logic en_lvl);
    cmd_in = cmd_lvl; en_n_in = en_lvl;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic turn_on();
    cmd_in = 1'b0; step(40);
    cmd_in = 1'b1; step(40);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b0);
    check("R1 gate after reset", gate_on, 1'b0);
    check("R1 clamp after reset", clamp_on, 1'b0);
    check("R1 flag after reset", flag_n, 1'b1);
    step(60);
    check("R1 high command at reset is not an edge", gate_on, 1'b0);
    cmd_in = 1'b0; step(40);
  endtask

  task automatic t_enable_default();
    do_reset(1'b0, 1'b1);
    cmd_in = 1'b1; step(40);
    check("R2 disabled enable blocks turn-on", gate_on, 1'b0);
    en_n_in = 1'b0; step(40);
    check("R2 enabling with command high needs new edge", gate_on, 1'b0);
    turn_on();
    check("R4 rising edge turns on", gate_on, 1'b1);
    cmd_in = 1'b0; step(40);
  endtask

  task automatic t_filter_flag();
    cmd_in = 1'b1; step(20);
    cmd_in = 1'b0; step(40);
    check("R3 short command pulse ignored", gate_on, 1'b0);
    cmd_in = 1'b1; step(32);
    check("R3 gate still off at edge 32", gate_on, 1'b0);
    step(1);
    check("R3 gate on at edge 33", gate_on, 1'b1);
    step(15);
    check("R11 flag high before filter time", flag_n, 1'b1);
    step(1);
    check("R11 flag low after 16 clocks", flag_n, 1'b0);
    i_at_flag = 1'b1; step(10);
    check("R11 flag still low within filter", flag_n, 1'b0);
    step(10);
    check("R11 flag high after threshold", flag_n, 1'b1);
    i_at_flag = 1'b0; step(20);
    check("R11 flag stays high after threshold", flag_n, 1'b1);
    cmd_in = 1'b0; step(32);
    check("R4 gate on before fall accepted", gate_on, 1'b1);
    step(1);
    check("R4 falling edge turns off", gate_on, 1'b0);
    check("R4 normal off has no clamp", clamp_on, 1'b0);
  endtask

  task automatic t_enable_event();
    turn_on();
    en_n_in = 1'b1; step(40);
    check("R6 enable loss clamps", clamp_on, 1'b1);
    check("R6 gate off in clamp", gate_on, 1'b0);
    en_n_in = 1'b0; step(40);
    check("R6 clamp held after enable returns", clamp_on, 1'b1);
    i_zero = 1'b1; step(2);
    check("R6 clamp released at zero current", clamp_on, 1'b0);
    i_zero = 1'b0; step(20);
    check("R6 no restart without new edge", gate_on, 1'b0);
    turn_on();
    check("R6 restart on fresh edge", gate_on, 1'b1);
    cmd_in = 1'b0; step(40);
  endtask

  task automatic t_thermal();
    turn_on();
    hot = 1'b1; step(2);
    check("R7 over-temperature clamps", clamp_on, 1'b1);
    i_zero = 1'b1; step(2);
    check("R7 clamp released at zero current", clamp_on, 1'b0);
    i_zero = 1'b0;
    turn_on();
    check("R7 no turn-on while hot", gate_on, 1'b0);
    hot = 1'b0;
    turn_on();
    check("R7 turn-on after cooling", gate_on, 1'b1);
    hot = 1'b1; step(2);
    check("R7 second thermal clamp", clamp_on, 1'b1);
    cmd_in = 1'b0; step(32);
    check("R7 clamp held until command fall accepted", clamp_on, 1'b1);
    step(1);
    check("R7 command fall drops clamp at once", clamp_on, 1'b0);
    hot = 1'b0; step(5);
  endtask

  task automatic t_supply();
    turn_on();
    sup_ov = 1'b1; step(440);
    check("R8 no clamp before persistence", clamp_on, 1'b0);
    step(1);
    check("R8 clamp after 440 samples", clamp_on, 1'b1);
    i_zero = 1'b1; step(2);
    check("R8 clamp released at zero current", clamp_on, 1'b0);
    i_zero = 1'b0;
    turn_on();
    check("R8 turn-on blocked during overvoltage", gate_on, 1'b0);
    sup_ov = 1'b0; step(40);
    check("R8 no level restart after clear", gate_on, 1'b0);
    turn_on();
    check("R8 restart on new edge", gate_on, 1'b1);
    sup_ov = 1'b1; step(300);
    sup_ov = 1'b0; step(1);
    sup_ov = 1'b1; step(300);
    check("R8 interrupted overvoltage restarts count", clamp_on, 1'b0);
    check("R8 gate stays on", gate_on, 1'b1);
    sup_ov = 1'b0;
    cmd_in = 1'b0; step(40);
  endtask

  task automatic t_inpov();
    turn_on();
    inp_ov = 1'b1; step(2);
    check("R9 input overvoltage clamps", clamp_on, 1'b1);
    check("R9 gate off during input overvoltage", gate_on, 1'b0);
    step(50);
    check("R9 clamp held while condition lasts", clamp_on, 1'b1);
    inp_ov = 1'b0; step(2);
    check("R9 clamp released on clear", clamp_on, 1'b0);
    check("R9 gate returns with command high", gate_on, 1'b1);
    cmd_in = 1'b0; step(40);
  endtask

  task automatic t_bond();
    turn_on();
    bond_fault = 1'b1; step(2);
    check("R10 bond fault clamps", clamp_on, 1'b1);
    bond_fault = 1'b0; step(20);
    check("R10 clamp held after flag clears", clamp_on, 1'b1);
    i_zero = 1'b1; step(2);
    check("R10 clamp released at zero current", clamp_on, 1'b0);
    check("R10 gate off after discharge", gate_on, 1'b0);
    i_zero = 1'b0;
    cmd_in = 1'b0; step(40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enable_default();
    t_filter_flag();
    t_enable_event();
    t_thermal();
    t_supply();
    t_inpov();
    t_bond();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule